// File: doc/BRIEF.md
# PWM Output Modulation and Pin Level Select

This block turns several PWM modulation sources into a set of output pin levels, one per channel (six by default). Each channel sees four sources. The first is its own compare-state bit. The second is a compare-state bit shared by every channel. The third is one bit of a multi-channel pattern word. The fourth is a trap flag. The compare-state bit, the shared bit and the trap each have an enable per channel. The pattern bits are gated by a single enable for the whole block. Sources that are enabled are ANDed into one active/passive line. An enabled trap forces that line passive.

A per-channel polarity bit then maps the line to a pin level. A passive line drives the polarity bit itself, and an active line drives its inverse. Software writes the polarity bits into a shadow copy. The working copy loads from the shadow only on a timer shadow-transfer strobe, so several PWM parameters can change on the same timer event without stray pulses on the pins. The timers, the compare logic, the pattern register and the trap detection sit outside this block and arrive as plain input signals.

Top module: `pwm_outmod`

## Requirements
- R1: A synchronous active-high reset clears every enable register, the global pattern enable, and both the shadow and working polarity bits to zero. With everything cleared, every pin reads 1.
- R2: A source whose enable is 0 has no effect on its channel's pin, whatever its value.
- R3: If any enabled source of a channel is passive (value 0), that channel's line is passive.
- R4: A channel's line is active only when all of its enabled sources are active (value 1). With no non-trap source enabled, the line is active.
- R5: When trap_state is 1 and a channel's trap enable bit is 1, that channel's line is passive regardless of every other source. A trap enable of 0 leaves the channel untouched by trap_state.
- R6: A passive line drives pin_out[i] equal to working polarity bit i. An active line drives its inverse.
- R7: A write to the polarity register (address 4) changes only the shadow. The working copy, which is what a read of address 4 returns and what drives the pins, loads from the shadow only in a cycle with shadow_xfer high.
- R8: A polarity write and a shadow_xfer in the same cycle load the working copy with the old shadow value and the shadow with the new value. The new value reaches the pins on the next strobe.
- R9: The pattern enable (address 3, bit 0) gates pattern[i] into every channel at once.
- R10: The register map is as follows. Address 0 holds the own-compare enables, address 1 the shared-compare enables and address 2 the trap enables, with bit i belonging to channel i. Address 3 bit 0 is the pattern enable and address 4 is the polarity register. Reads are combinational from reg_addr. Unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | AW (3) | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DW (8) | Register write data |
| reg_rdata | output | DW (8) | Register read data, combinational |
| chan_state | input | NUM_OUT (6) | Per-channel compare-state bits, 1 = active |
| shared_state | input | 1 | Shared compare-state bit, 1 = active |
| pattern | input | NUM_OUT (6) | Multi-channel pattern bits, 1 = active |
| trap_state | input | 1 | Trap flag, 1 = trap in force |
| shadow_xfer | input | 1 | Timer shadow-transfer strobe |
| pin_out | output | NUM_OUT (6) | Output pin levels |

## Verification
Two events can land in the same clock: a software write to the polarity register and the timer shadow-transfer strobe. The bench forces them to coincide in a directed step and keeps going with the strobe held high. It checks that the pins and the read value show the old shadow on the first cycle and the new value only after the following strobe. Random stimulus also lets trap assertion overlap with enable-register writes. A behavioural model, updated once per clock and compared on every cycle, judges both the pins and the read data.

// File: rtl/pwm_outmod_pkg.sv
package pwm_outmod_pkg;
   localparam int unsigned ADDR_OWN_EN   = 0;
   localparam int unsigned ADDR_SHR_EN   = 1;
   localparam int unsigned ADDR_TRAP_EN  = 2;
   localparam int unsigned ADDR_PAT_EN   = 3;
   localparam int unsigned ADDR_POLARITY = 4;
   localparam int unsigned MIN_AW        = 3;

   typedef enum logic {
      LINE_PASSIVE = 1'b0,
      LINE_ACTIVE  = 1'b1
   } line_state_e;
endpackage

// File: rtl/pwm_outmod_regs.sv
module pwm_outmod_regs
   import pwm_outmod_pkg::*;
#(
   parameter int unsigned NUM_OUT = 6,
   parameter int unsigned AW      = 3,
   parameter int unsigned DW      = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [AW-1:0]      reg_addr,
   input  logic               reg_we,
   input  logic [DW-1:0]      reg_wdata,
   output logic [DW-1:0]      reg_rdata,
   input  logic               shadow_xfer,
   output logic [NUM_OUT-1:0] own_en,
   output logic [NUM_OUT-1:0] sh_en,
   output logic [NUM_OUT-1:0] trap_en,
   output logic               pat_en,
   output logic [NUM_OUT-1:0] psl_shadow,
   output logic [NUM_OUT-1:0] psl_work
);
   localparam int unsigned PAD = DW - NUM_OUT;

   logic hit_own, hit_shr, hit_trap, hit_pat, hit_pol;

   always_comb begin
      hit_own  = (reg_addr == AW'(ADDR_OWN_EN));
      hit_shr  = (reg_addr == AW'(ADDR_SHR_EN));
      hit_trap = (reg_addr == AW'(ADDR_TRAP_EN));
      hit_pat  = (reg_addr == AW'(ADDR_PAT_EN));
      hit_pol  = (reg_addr == AW'(ADDR_POLARITY));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         own_en  <= '0;
         sh_en   <= '0;
         trap_en <= '0;
         pat_en  <= 1'b0;
      end else if (reg_we) begin
         if (hit_own)  own_en  <= reg_wdata[NUM_OUT-1:0];
         if (hit_shr)  sh_en   <= reg_wdata[NUM_OUT-1:0];
         if (hit_trap) trap_en <= reg_wdata[NUM_OUT-1:0];
         if (hit_pat)  pat_en  <= reg_wdata[0];
      end
   end

   // Double-buffered polarity: write lands in shadow, strobe copies to work.
   always_ff @(posedge clk) begin
      if (rst) begin
         psl_shadow <= '0;
         psl_work   <= '0;
      end else begin
         if (shadow_xfer)         psl_work   <= psl_shadow;
         if (reg_we && hit_pol)   psl_shadow <= reg_wdata[NUM_OUT-1:0];
      end
   end

   logic [NUM_OUT-1:0] rd_sel;

   always_comb begin
      rd_sel = '0;
      if (hit_own)  rd_sel = own_en;
      if (hit_shr)  rd_sel = sh_en;
      if (hit_trap) rd_sel = trap_en;
      if (hit_pat)  rd_sel = NUM_OUT'(pat_en);
      if (hit_pol)  rd_sel = psl_work;
   end

   generate
      if (PAD > 0) begin : g_pad
         assign reg_rdata = {{PAD{1'b0}}, rd_sel};
      end else begin : g_nopad
         assign reg_rdata = rd_sel;
      end
   endgenerate
endmodule

// File: rtl/pwm_outmod_combine.sv
module pwm_outmod_combine
   import pwm_outmod_pkg::*;
#(
   parameter int unsigned NUM_OUT = 6
) (
   input  logic [NUM_OUT-1:0] chan_state,
   input  logic               shared_state,
   input  logic [NUM_OUT-1:0] pattern,
   input  logic               trap_state,
   input  logic [NUM_OUT-1:0] own_en,
   input  logic [NUM_OUT-1:0] sh_en,
   input  logic [NUM_OUT-1:0] trap_en,
   input  logic               pat_en,
   output line_state_e        line [NUM_OUT]
);
   generate
      for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_ch
         logic own_ok, shr_ok, pat_ok, trapped;
         always_comb begin
            own_ok  = !own_en[ch] || chan_state[ch];
            shr_ok  = !sh_en[ch]  || shared_state;
            pat_ok  = !pat_en     || pattern[ch];
            trapped = trap_en[ch] && trap_state;
            line[ch] = (own_ok && shr_ok && pat_ok && !trapped) ? LINE_ACTIVE
                                                                : LINE_PASSIVE;
         end
      end
   endgenerate
endmodule

// File: rtl/pwm_outmod_level.sv
module pwm_outmod_level
   import pwm_outmod_pkg::*;
#(
   parameter int unsigned NUM_OUT = 6
) (
   input  line_state_e        line [NUM_OUT],
   input  logic [NUM_OUT-1:0] psl_work,
   output logic [NUM_OUT-1:0] pin_out
);
   generate
      for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_lvl
         assign pin_out[ch] = (line[ch] == LINE_ACTIVE) ? ~psl_work[ch]
                                                        :  psl_work[ch];
      end
   endgenerate
endmodule

// File: rtl/pwm_outmod.sv
module pwm_outmod
   import pwm_outmod_pkg::*;
#(
   parameter int unsigned NUM_OUT = 6,
   parameter int unsigned AW      = 3,
   parameter int unsigned DW      = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [AW-1:0]      reg_addr,
   input  logic               reg_we,
   input  logic [DW-1:0]      reg_wdata,
   output logic [DW-1:0]      reg_rdata,
   input  logic [NUM_OUT-1:0] chan_state,
   input  logic               shared_state,
   input  logic [NUM_OUT-1:0] pattern,
   input  logic               trap_state,
   input  logic               shadow_xfer,
   output logic [NUM_OUT-1:0] pin_out
);
   generate
      if (NUM_OUT < 1) begin : g_bad_n
         $error("pwm_outmod: NUM_OUT must be at least 1");
      end
      if (DW < NUM_OUT) begin : g_bad_dw
         $error("pwm_outmod: DW must hold NUM_OUT bits");
      end
      if (AW < MIN_AW) begin : g_bad_aw
         $error("pwm_outmod: AW too narrow for the register map");
      end
   endgenerate

   logic [NUM_OUT-1:0] own_en, sh_en, trap_en, psl_shadow, psl_work;
   logic               pat_en;
   line_state_e        line [NUM_OUT];

   pwm_outmod_regs #(.NUM_OUT(NUM_OUT), .AW(AW), .DW(DW)) u_regs (
      .clk        (clk),
      .rst        (rst),
      .reg_addr   (reg_addr),
      .reg_we     (reg_we),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .shadow_xfer(shadow_xfer),
      .own_en     (own_en),
      .sh_en      (sh_en),
      .trap_en    (trap_en),
      .pat_en     (pat_en),
      .psl_shadow (psl_shadow),
      .psl_work   (psl_work)
   );

   pwm_outmod_combine #(.NUM_OUT(NUM_OUT)) u_comb (
      .chan_state  (chan_state),
      .shared_state(shared_state),
      .pattern     (pattern),
      .trap_state  (trap_state),
      .own_en      (own_en),
      .sh_en       (sh_en),
      .trap_en     (trap_en),
      .pat_en      (pat_en),
      .line        (line)
   );

   pwm_outmod_level #(.NUM_OUT(NUM_OUT)) u_lvl (
      .line    (line),
      .psl_work(psl_work),
      .pin_out (pin_out)
   );
endmodule

// File: rtl/pwm_outmod_chk.sv
module pwm_outmod_chk #(
   parameter int unsigned NUM_OUT = 6
) (
   input logic               clk,
   input logic               rst,
   input logic [NUM_OUT-1:0] chan_state,
   input logic               shared_state,
   input logic [NUM_OUT-1:0] pattern,
   input logic               trap_state,
   input logic               shadow_xfer,
   input logic [NUM_OUT-1:0] pin_out,
   input logic [NUM_OUT-1:0] own_en,
   input logic [NUM_OUT-1:0] sh_en,
   input logic [NUM_OUT-1:0] trap_en,
   input logic               pat_en,
   input logic [NUM_OUT-1:0] psl_shadow,
   input logic [NUM_OUT-1:0] psl_work
);
   logic [NUM_OUT-1:0] inverted, any_passive, all_ok;

   always_comb begin
      inverted    = pin_out ^ psl_work;
      any_passive = (own_en & ~chan_state)
                  | (sh_en & {NUM_OUT{~shared_state}})
                  | ({NUM_OUT{pat_en}} & ~pattern);
      all_ok      = ~any_passive & ~(trap_en & {NUM_OUT{trap_state}});
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (own_en == '0 && sh_en == '0 && trap_en == '0 && !pat_en
               && psl_shadow == '0 && psl_work == '0));

   assert_passive_wins_R3: assert property (@(posedge clk) disable iff (rst)
      (any_passive & inverted) == '0);

   assert_all_active_R4: assert property (@(posedge clk) disable iff (rst)
      (all_ok & ~inverted) == '0);

   assert_trap_forces_R5: assert property (@(posedge clk) disable iff (rst)
      trap_state |-> ((inverted & trap_en) == '0));

   assert_work_holds_R7: assert property (@(posedge clk) disable iff (rst)
      !shadow_xfer |=> $stable(psl_work));

   assert_xfer_old_shadow_R8: assert property (@(posedge clk) disable iff (rst)
      shadow_xfer |=> (psl_work == $past(psl_shadow)));
endmodule

bind pwm_outmod pwm_outmod_chk #(.NUM_OUT(NUM_OUT)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .chan_state  (chan_state),
   .shared_state(shared_state),
   .pattern     (pattern),
   .trap_state  (trap_state),
   .shadow_xfer (shadow_xfer),
   .pin_out     (pin_out),
   .own_en      (own_en),
   .sh_en       (sh_en),
   .trap_en     (trap_en),
   .pat_en      (pat_en),
   .psl_shadow  (psl_shadow),
   .psl_work    (psl_work)
);

// File: tb/pwm_outmod_test.sv
module pwm_outmod_test;
   localparam int N  = 6;
   localparam int AW = 3;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_we = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [N-1:0]  chan_state = '0;
   logic          shared_state = 1'b0;
   logic [N-1:0]  pattern = '0;
   logic          trap_state = 1'b0;
   logic          shadow_xfer = 1'b0;
   logic [N-1:0]  pin_out;

   always #4 clk = ~clk;

   pwm_outmod #(.NUM_OUT(N), .AW(AW), .DW(DW)) uut (
      .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chan_state(chan_state),
      .shared_state(shared_state), .pattern(pattern), .trap_state(trap_state),
      .shadow_xfer(shadow_xfer), .pin_out(pin_out)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string tag = "R1";

   // Behavioural reference state
   bit [N-1:0] m_own = '0, m_shr = '0, m_trap = '0, m_shadow = '0, m_work = '0;
   bit         m_pat = 1'b0;

   task automatic model_update();
      if (rst) begin
         m_own = '0; m_shr = '0; m_trap = '0; m_pat = 1'b0;
         m_shadow = '0; m_work = '0;
      end else begin
         if (shadow_xfer) m_work = m_shadow;
         if (reg_we) begin
            case (int'(reg_addr))
               0: m_own    = reg_wdata[N-1:0];
               1: m_shr    = reg_wdata[N-1:0];
               2: m_trap   = reg_wdata[N-1:0];
               3: m_pat    = reg_wdata[0];
               4: m_shadow = reg_wdata[N-1:0];
               default: ;
            endcase
         end
      end
   endtask

   task automatic compare();
      bit [N-1:0]  exp_pin;
      bit [DW-1:0] exp_rd;
      for (int i = 0; i < N; i++) begin
         bit act;
         act = 1'b1;
         if (m_own[i] && !chan_state[i]) act = 1'b0;
         if (m_shr[i] && !shared_state)  act = 1'b0;
         if (m_pat && !pattern[i])       act = 1'b0;
         if (m_trap[i] && trap_state)    act = 1'b0;
         exp_pin[i] = act ? ~m_work[i] : m_work[i];
      end
      case (int'(reg_addr))
         0: exp_rd = DW'(m_own);
         1: exp_rd = DW'(m_shr);
         2: exp_rd = DW'(m_trap);
         3: exp_rd = DW'(m_pat);
         4: exp_rd = DW'(m_work);
         default: exp_rd = '0;
      endcase
      n_cmp++;
      if (pin_out !== exp_pin) begin
         n_bad++;
         $display("FAIL %s pin_out actual=%b expected=%b", tag, pin_out, exp_pin);
      end
      n_cmp++;
      if (reg_rdata !== exp_rd) begin
         n_bad++;
         $display("FAIL %s R10 reg_rdata actual=%h expected=%h", tag, reg_rdata, exp_rd);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      model_update();
      compare();
   endtask

   task automatic wr(input int a, input int d);
      reg_addr = AW'(a); reg_wdata = DW'(d); reg_we = 1'b1;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic drive(input bit [N-1:0] cs, input bit sh, input bit [N-1:0] pt, input bit tr);
      chan_state = cs; shared_state = sh; pattern = pt; trap_state = tr;
      tick();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state, all registers zero, all pins 1
      tag = "R1";
      repeat (3) tick();
      for (int a = 0; a < 8; a++) begin reg_addr = AW'(a); tick(); end
      rst = 1'b0;
      tick();

      // R10: readback, unused bits and unmapped address
      tag = "R10";
      wr(0, 8'hFF); reg_addr = 0; tick();
      wr(0, 8'h15); tick();
      wr(5, 8'hAA); reg_addr = 5; tick();
      wr(3, 8'hFE); reg_addr = 3; tick();
      wr(0, 0);

      // R2: disabled sources ignored (nothing enabled, toggle inputs)
      tag = "R2";
      drive(6'h2A, 1'b0, 6'h15, 1'b1);
      drive(6'h00, 1'b1, 6'h3F, 1'b1);
      drive(6'h3F, 1'b0, 6'h00, 1'b0);

      // R3/R4: own and shared enables combine
      tag = "R3";
      wr(0, 8'h3F); wr(1, 8'h0F);
      drive(6'h3F, 1'b0, 6'h00, 1'b0);
      drive(6'h0C, 1'b1, 6'h00, 1'b0);
      tag = "R4";
      drive(6'h3F, 1'b1, 6'h00, 1'b0);
      wr(0, 0); wr(1, 0);
      drive(6'h00, 1'b0, 6'h00, 1'b0);

      // R9: global pattern enable
      tag = "R9";
      wr(3, 1);
      drive(6'h00, 1'b0, 6'h29, 1'b0);
      drive(6'h00, 1'b0, 6'h16, 1'b0);
      wr(3, 0);
      drive(6'h00, 1'b0, 6'h16, 1'b0);

      // R5: trap per enabled channel
      tag = "R5";
      wr(2, 8'h33);
      drive(6'h3F, 1'b1, 6'h3F, 1'b1);
      drive(6'h3F, 1'b1, 6'h3F, 1'b0);
      wr(2, 0);
      drive(6'h3F, 1'b1, 6'h3F, 1'b1);

      // R6/R7: shadowed polarity
      tag = "R7";
      wr(4, 8'h2D); reg_addr = 4; tick(); tick();
      tag = "R6";
      shadow_xfer = 1'b1; tick(); shadow_xfer = 1'b0; tick();
      wr(1, 8'h3F);
      drive(6'h00, 1'b0, 6'h00, 1'b0);
      drive(6'h00, 1'b1, 6'h00, 1'b0);
      wr(1, 0);

      // R8: write and strobe in the same cycle, strobe held on
      tag = "R8";
      wr(4, 8'h12);
      shadow_xfer = 1'b1;
      wr(4, 8'h05);
      reg_addr = 4; tick(); tick();
      shadow_xfer = 1'b0;
      wr(4, 8'h3C); tick();
      shadow_xfer = 1'b1; wr(4, 8'h01); shadow_xfer = 1'b0; tick();

      // Mixed random traffic
      tag = "R2/R3/R4/R5/R6/R7/R8/R9";
      for (int k = 0; k < 4000; k++) begin
         chan_state   = N'($urandom);
         shared_state = 1'($urandom);
         pattern      = N'($urandom);
         trap_state   = (($urandom % 8) == 0);
         shadow_xfer  = (($urandom % 6) == 0);
         reg_addr     = AW'($urandom);
         reg_wdata    = DW'($urandom);
         reg_we       = (($urandom % 4) == 0);
         tick();
      end
      reg_we = 1'b0; shadow_xfer = 1'b0;
      tick();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule